// File: doc/BRIEF.md
# Prioritized DMA Slot Arbiter

The block decides, once per color clock, which requester owns the shared chip-memory bus. Nine DMA requesters compete under a fixed order: disk first, then sprite, bitplane, coprocessor, blitter, and the four audio channels. The CPU is last and takes any cycle that no DMA requester claims. A requester is eligible only when its own enable bit and the master enable bit in a 16-bit control register are both set.

Software changes the control register through a plain write strobe. Bit 15 of the written word selects the mode. In set mode every bit written as 1 becomes 1. In clear mode every bit written as 1 becomes 0. Bits written as 0 keep their value. The read port returns the enables together with two status flags that come in from the blitter. A free-running color-clock counter gives the beam position within a 228-clock raster line and pulses a line-start flag at each wrap.

Each clock cycle is one color clock. Requests and the grant are plain level signals with no valid/ready handshake and no back-pressure. The grant is combinational, valid in the same cycle as the requests, and a requester that is granted owns that one cycle only. A register write takes effect from the next cycle.

Top module: `dma_slot_arbiter`

## Requirements
- R1: Among eligible requesters the grant goes to the highest in the order disk, sprite, bitplane, coprocessor, blitter, audio. The grant vector is indexed 0 disk, 1 sprite, 2 bitplane, 3 coprocessor, 4 blitter, 5..8 audio 0..3, 9 CPU.
- R2: Exactly one grant bit is high in every cycle. The CPU bit (9) is high exactly when no eligible DMA request is present.
- R3: A write with bit 15 = 1 sets each of bits 9..0 that is written as 1. A write with bit 15 = 0 clears each of those bits written as 1. Bits written as 0, and all bits in cycles without a write, keep their value. The change is visible from the cycle after the write.
- R4: Read data bit 15 is always 0, bit 14 follows the blitter-busy input, and bit 13 follows the blitter-zero input. Bits 12..10 read 0. Writes have no effect on bits 15..10.
- R5: While master enable (bit 9) is 0, no DMA requester is granted and the CPU receives every cycle.
- R6: Enable bits are 8 bitplane, 7 coprocessor, 6 blitter, 5 sprite, 4 disk, and 3..0 audio 3..0. A requester whose enable bit is 0 is never granted.
- R7: The beam position counts 0..227 and wraps to 0. The line-start output is high in exactly the cycle in which the position is 0 after a wrap from 227, so line starts are 228 cycles apart.
- R8: During reset the control enables are 0, the beam position is 0, line-start is 0 and the grant is the CPU.
- R9: When several audio channels request at once, the lowest-numbered eligible channel wins.
- R10: The grant reflects the requests of the same cycle, without a register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Color clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 16 | Write word; bit 15 selects set (1) or clear (0) |
| ctl_rd_data | output | 16 | Control register read value with status flags |
| blit_busy_i | input | 1 | Blitter busy status, reported on read bit 14 |
| blit_zero_i | input | 1 | Blitter zero status, reported on read bit 13 |
| req_disk | input | 1 | Disk DMA request |
| req_sprite | input | 1 | Sprite DMA request |
| req_bitplane | input | 1 | Bitplane DMA request |
| req_copro | input | 1 | Coprocessor DMA request |
| req_blitter | input | 1 | Blitter DMA request |
| req_audio | input | 4 | Audio channel 3..0 DMA requests |
| slot_grant | output | 10 | One-hot grant, index order as in R1 |
| beam_pos | output | 8 | Color-clock position within the line |
| line_start | output | 1 | Pulse at the first clock of each new line |

## Verification
The assertions check the one-hot grant and the CPU fallback on every cycle. They also check that no granted requester lacks a request or its enables, and that the master gate holds. On the register side they check the set, clear and hold behaviour of the control bits, and on the counter side the wrap from 227 with its aligned line-start pulse. Only the bench scenarios can show the full priority ranking between specific requester pairs, the audio tie order and the exact read-back values after a sequence of writes. They also show that writes to the status and reserved bits have no effect, and that line starts are 228 cycles apart.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int unsigned CTL_W     = 16;
  localparam int unsigned NUM_DMA   = 9;
  localparam int unsigned GRANT_W   = NUM_DMA + 1;
  localparam int unsigned CPU_IDX   = NUM_DMA;

  // control register bit positions (decoded by the arbiter)
  localparam int unsigned B_MODE    = 15;
  localparam int unsigned B_BBUSY   = 14;
  localparam int unsigned B_BZERO   = 13;
  localparam int unsigned B_MASTER  = 9;
  localparam int unsigned B_BPL     = 8;
  localparam int unsigned B_COP     = 7;
  localparam int unsigned B_BLT     = 6;
  localparam int unsigned B_SPR     = 5;
  localparam int unsigned B_DSK     = 4;
  localparam int unsigned EN_W      = 10;

  // grant vector indices, highest priority first
  typedef enum logic [3:0] {
    G_DISK = 4'd0, G_SPRITE = 4'd1, G_BITPLANE = 4'd2, G_COPRO = 4'd3,
    G_BLITTER = 4'd4, G_AUD0 = 4'd5, G_AUD1 = 4'd6, G_AUD2 = 4'd7,
    G_AUD3 = 4'd8, G_CPU = 4'd9
  } grant_idx_e;
endpackage

// File: rtl/dma_ctl_reg.sv
module dma_ctl_reg
  import dma_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  input  logic             bbusy,
  input  logic             bzero,
  output logic [EN_W-1:0]  enables,
  output logic [CTL_W-1:0] rd_data
);
  localparam logic [CTL_W-2:0] WR_MASK = (CTL_W-1)'((1 << EN_W) - 1);

  logic [CTL_W-2:0] sel_bits;
  logic [EN_W-1:0]  sel;
  logic [EN_W-1:0]  ctl_q;

  assign sel_bits = wr_data[CTL_W-2:0] & WR_MASK;
  assign sel      = sel_bits[EN_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)
      ctl_q <= '0;
    else if (wr_en) begin
      if (wr_data[B_MODE]) ctl_q <= ctl_q | sel;
      else                 ctl_q <= ctl_q & ~sel;
    end
  end

  assign enables = ctl_q;

  always_comb begin
    rd_data           = '0;
    rd_data[EN_W-1:0] = ctl_q;
    rd_data[B_BBUSY]  = bbusy;
    rd_data[B_BZERO]  = bzero;
  end

  // R3: set mode raises every selected bit
  assert_set_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[B_MODE]) |=>
      ((ctl_q & $past(wr_data[EN_W-1:0])) == $past(wr_data[EN_W-1:0])));
  // R3: clear mode drops every selected bit
  assert_clear_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[B_MODE]) |=> ((ctl_q & $past(wr_data[EN_W-1:0])) == '0));
  // R3: unselected bits keep their value
  assert_hold_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (((ctl_q ^ $past(ctl_q)) & ~$past(wr_data[EN_W-1:0])) == '0));
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctl_q));
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int unsigned N = 9
) (
  input  logic [N-1:0] req,
  output logic [N:0]   grant
);
  logic [N:0] taken;

  assign taken[0] = 1'b0;

  generate
    for (genvar i = 0; i < N; i++) begin : g_stage
      assign grant[i]   = req[i] & ~taken[i];
      assign taken[i+1] = taken[i] | req[i];
    end
  endgenerate

  assign grant[N] = ~taken[N];

  // R1: a DMA grant only goes to a live request
  always_comb begin
    assert_grant_has_req_R1: assert ((grant[N-1:0] & ~req) == '0);
  end
endmodule

// File: rtl/dma_beam_count.sv
module dma_beam_count #(
  parameter int unsigned LINE_LEN = 228,
  localparam int unsigned POS_W   = $clog2(LINE_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [POS_W-1:0] pos,
  output logic             line_start
);
  localparam logic [POS_W-1:0] LAST = POS_W'(LINE_LEN - 1);

  logic [POS_W-1:0] pos_q;
  logic             start_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q   <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= (pos_q == LAST);
      pos_q   <= (pos_q == LAST) ? '0 : pos_q + 1'b1;
    end
  end

  assign pos        = pos_q;
  assign line_start = start_q;

  assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q == LAST) |=> (pos_q == '0) && start_q);
  assert_start_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> (pos_q == '0));
endmodule

// File: rtl/dma_slot_arbiter.sv
module dma_slot_arbiter
  import dma_arb_pkg::*;
#(
  parameter int unsigned LINE_LEN = 228,
  localparam int unsigned POS_W   = $clog2(LINE_LEN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_wr_en,
  input  logic [CTL_W-1:0]   ctl_wr_data,
  output logic [CTL_W-1:0]   ctl_rd_data,
  input  logic               blit_busy_i,
  input  logic               blit_zero_i,
  input  logic               req_disk,
  input  logic               req_sprite,
  input  logic               req_bitplane,
  input  logic               req_copro,
  input  logic               req_blitter,
  input  logic [3:0]         req_audio,
  output logic [GRANT_W-1:0] slot_grant,
  output logic [POS_W-1:0]   beam_pos,
  output logic               line_start
);
  logic [EN_W-1:0]    en;
  logic [NUM_DMA-1:0] req_raw;
  logic [NUM_DMA-1:0] en_map;
  logic [NUM_DMA-1:0] req_ok;

  dma_ctl_reg u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ctl_wr_en),
    .wr_data (ctl_wr_data),
    .bbusy   (blit_busy_i),
    .bzero   (blit_zero_i),
    .enables (en),
    .rd_data (ctl_rd_data)
  );

  // requests and enables in priority order (index 0 highest)
  assign req_raw = {req_audio, req_blitter, req_copro, req_bitplane,
                    req_sprite, req_disk};
  assign en_map  = {en[3], en[2], en[1], en[0], en[B_BLT], en[B_COP],
                    en[B_BPL], en[B_SPR], en[B_DSK]};
  assign req_ok  = req_raw & en_map & {NUM_DMA{en[B_MASTER]}};

  dma_prio_pick #(.N(NUM_DMA)) u_pick (
    .req   (req_ok),
    .grant (slot_grant)
  );

  dma_beam_count #(.LINE_LEN(LINE_LEN)) u_beam (
    .clk        (clk),
    .rst_n      (rst_n),
    .pos        (beam_pos),
    .line_start (line_start)
  );

  assert_one_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(slot_grant) == 1);
  assert_master_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rd_data[B_MASTER] |-> slot_grant[CPU_IDX]);
  assert_enable_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_grant[NUM_DMA-1:0] & ~(req_raw & en_map)) == '0);
  assert_cpu_leftover_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd_data[B_MASTER] && ((req_raw & en_map) != '0)) |-> !slot_grant[CPU_IDX]);
endmodule

// File: tb/test_dma_slot_arbiter.sv
module test_dma_slot_arbiter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_wr_en;
  logic [15:0] ctl_wr_data;
  logic [15:0] ctl_rd_data;
  logic        blit_busy_i, blit_zero_i;
  logic        req_disk, req_sprite, req_bitplane, req_copro, req_blitter;
  logic [3:0]  req_audio;
  logic [9:0]  slot_grant;
  logic [7:0]  beam_pos;
  logic        line_start;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  dma_slot_arbiter i_dma_slot_arbiter (
    .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .ctl_rd_data(ctl_rd_data), .blit_busy_i(blit_busy_i), .blit_zero_i(blit_zero_i),
    .req_disk(req_disk), .req_sprite(req_sprite), .req_bitplane(req_bitplane),
    .req_copro(req_copro), .req_blitter(req_blitter), .req_audio(req_audio),
    .slot_grant(slot_grant), .beam_pos(beam_pos), .line_start(line_start)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] oh(input int idx);
    return 10'(1) << idx;
  endfunction

  task automatic wr(input logic [15:0] d);
    @(negedge clk);
    ctl_wr_en = 1'b1; ctl_wr_data = d;
    @(negedge clk);
    ctl_wr_en = 1'b0; ctl_wr_data = '0;
  endtask

  task automatic drive(input logic [8:0] r);
    @(negedge clk);
    {req_audio, req_blitter, req_copro, req_bitplane, req_sprite, req_disk} = r;
    #1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; ctl_wr_en = 1'b0; ctl_wr_data = '0;
    blit_busy_i = 1'b0; blit_zero_i = 1'b0;
    {req_audio, req_blitter, req_copro, req_bitplane, req_sprite, req_disk} = '1;
    repeat (3) @(negedge clk);
    check("R8 ctl reset", ctl_rd_data, 16'h0000);
    check("R8 grant cpu in reset", {6'b0, slot_grant}, {6'b0, oh(9)});
    check("R8 beam pos", {8'b0, beam_pos}, 16'd0);
    check("R8 line_start", {15'b0, line_start}, 16'd0);
    rst_n = 1'b1;
    {req_audio, req_blitter, req_copro, req_bitplane, req_sprite, req_disk} = '0;
  endtask

  task automatic t_set_clear;
    wr(16'h8380); #1;
    check("R3 set 8380", ctl_rd_data, 16'h0380);
    wr(16'h800F); #1;
    check("R3 set 800F keeps earlier", ctl_rd_data, 16'h038F);
    wr(16'h0300); #1;
    check("R3 clear 0300", ctl_rd_data, 16'h008F);
    wr(16'h0000); #1;
    check("R3 clear nothing", ctl_rd_data, 16'h008F);
    wr(16'h0000); wr(16'h0081); #1;
    check("R3 clear 0081", ctl_rd_data, 16'h000E);
  endtask

  task automatic t_readback;
    wr(16'hFC00); #1;
    check("R4 reserved/status writes ignored", ctl_rd_data, 16'h000E);
    blit_busy_i = 1'b1; blit_zero_i = 1'b0; #1;
    check("R4 busy flag", ctl_rd_data, 16'h400E);
    blit_busy_i = 1'b0; blit_zero_i = 1'b1; #1;
    check("R4 zero flag", ctl_rd_data, 16'h200E);
    wr(16'h7C0E); #1;
    check("R4 clear of status bits ignored", ctl_rd_data, 16'h2000);
    blit_zero_i = 1'b0;
  endtask

  task automatic t_priority;
    wr(16'h83FF); #1;
    check("R3 all enabled", ctl_rd_data, 16'h03FF);
    for (int k = 0; k < 9; k++) begin
      drive(9'h1FF << k);
      check($sformatf("R1 top requester %0d", k), {6'b0, slot_grant}, {6'b0, oh(k)});
    end
    drive(9'b0_0000_1010);
    check("R1 sprite beats coprocessor", {6'b0, slot_grant}, {6'b0, oh(1)});
    drive(9'b0_0001_1100);
    check("R1 bitplane beats blitter", {6'b0, slot_grant}, {6'b0, oh(2)});
    drive(9'b0);
  endtask

  task automatic t_audio_order;
    drive(9'b1100_00000);
    check("R9 aud2 beats aud3", {6'b0, slot_grant}, {6'b0, oh(7)});
    drive(9'b1010_00000);
    check("R9 aud1 beats aud3", {6'b0, slot_grant}, {6'b0, oh(6)});
    drive(9'b1111_00000);
    check("R9 aud0 wins all", {6'b0, slot_grant}, {6'b0, oh(5)});
    drive(9'b0);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    req_blitter = 1'b1; #1;
    check("R10 grant same cycle", {6'b0, slot_grant}, {6'b0, oh(4)});
    req_blitter = 1'b0; #1;
    check("R10 release same cycle", {6'b0, slot_grant}, {6'b0, oh(9)});
  endtask

  task automatic t_cpu_leftover;
    drive(9'b0);
    check("R2 idle -> cpu", {6'b0, slot_grant}, {6'b0, oh(9)});
    drive(9'b0_0001_0000);
    check("R2 blitter takes slot", {6'b0, slot_grant}, {6'b0, oh(4)});
  endtask

  task automatic t_channel_gate;
    wr(16'h0100);
    drive(9'b0_0000_1100);
    check("R6 bitplane disabled -> copro", {6'b0, slot_grant}, {6'b0, oh(3)});
    drive(9'b0_0000_0100);
    check("R6 only disabled bitplane -> cpu", {6'b0, slot_grant}, {6'b0, oh(9)});
    wr(16'h0001);
    drive(9'b0011_00000);
    check("R6 aud0 disabled -> aud1", {6'b0, slot_grant}, {6'b0, oh(6)});
    wr(16'h8101);
  endtask

  task automatic t_master_gate;
    wr(16'h0200);
    drive(9'h1FF);
    check("R5 master off -> cpu", {6'b0, slot_grant}, {6'b0, oh(9)});
    check("R5 enables kept", ctl_rd_data, 16'h01FF);
    wr(16'h8200);
    drive(9'h1FF);
    check("R5 master on -> disk", {6'b0, slot_grant}, {6'b0, oh(0)});
    drive(9'b0);
  endtask

  task automatic t_line;
    int guard;
    int gap;
    guard = 0;
    @(negedge clk);
    while (!line_start && guard < 600) begin
      @(negedge clk); guard++;
    end
    check("R7 line_start seen", {15'b0, line_start}, 16'd1);
    check("R7 pos zero at start", {8'b0, beam_pos}, 16'd0);
    gap = 0;
    do begin
      @(negedge clk); gap++;
      if (gap == 227) check("R7 last position", {8'b0, beam_pos}, 16'd227);
      if (gap < 228 && line_start) check("R7 early line_start", 16'd1, 16'd0);
    end while (!line_start && gap < 600);
    check("R7 line length", 16'(gap), 16'd228);
    check("R7 wrap to zero", {8'b0, beam_pos}, 16'd0);
  endtask

  initial begin
    t_reset();
    t_set_clear();
    t_readback();
    t_priority();
    t_audio_order();
    t_same_cycle();
    t_cpu_leftover();
    t_channel_gate();
    t_master_gate();
    t_line();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule